// File: doc/BRIEF.md
# Branch Target Flag State Tracker

This block keeps one bit of control-flow state for a small processor core. Some indirect branches and some loads that write the program counter set the flag when they retire. While the flag is set, the next retired instruction must be the dedicated clearing instruction. Any other instruction in that slot raises a usage-fault pulse toward the fault logic, and the flag returns to zero.

The decode stage presents a class code, a destination register number, a base or target register number and a write-back bit with every retire strobe. The tracker decides from these operands whether the instruction sets the flag. It also decides whether a retire that follows a set flag is legal. Both outputs are registered and change on the clock edge that samples the retire strobe. An enable input turns the whole mechanism off.

Top module: `btf_tracker`

## Requirements
- R1: While reset is high, and on the first sampled edge after it, `flag` and `fault` are both 0.
- R2: Class 2 (call-with-exchange) and class 3 (its non-secure form) retired with `flag` at 0 set `flag` to 1, whatever the operands.
- R3: Class 4 (branch-with-exchange) and class 5 (its non-secure form) retired with `flag` at 0 set `flag` to 1 only when `base_reg` is not 14 (the link register).
- R4: Class 6 (register-offset load) and class 7 (literal load) retired with `flag` at 0 set `flag` to 1 when `dst_reg` is 15 (the PC).
- R5: Class 8 (immediate-offset load) and class 9 (increment/decrement multiple load, with `dst_reg` of 15 meaning the PC is in the list) set `flag` to 1 only when `dst_reg` is 15 and either `base_reg` is not 13 (the stack pointer) or `base_wb` is 0.
- R6: Any other class code (0, 1, and 10 to 15), and any load whose `dst_reg` is not 15, leaves `flag` at 0 and `fault` at 0 when retired with `flag` at 0.
- R7: With `flag` at 1, retiring class 1 (clear) returns `flag` to 0 without a fault.
- R8: With `flag` at 1, retiring any class other than 1 drives `fault` to 1 for exactly one cycle and clears `flag` on the same edge, even if that instruction would itself set the flag.
- R9: Cycles without `retire` keep `flag` unchanged and `fault` at 0.
- R10: With `en` at 0, `flag` and `fault` are 0 on the next edge, and retired instructions neither set the flag nor fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables the tracking mechanism |
| retire | input | 1 | One instruction retires this cycle |
| ins_class | input | 4 | Decoded instruction class code |
| dst_reg | input | 4 | Destination register number (15 = PC) |
| base_reg | input | 4 | Base or branch-target register number |
| base_wb | input | 1 | Base register write-back requested |
| flag | output | 1 | Current flag state |
| fault | output | 1 | One-cycle invalid-state usage fault pulse |

## Verification
Setting the flag and judging the flag collide when a setting instruction retires directly after another setting instruction. In that case the fault decision must win, and the flag must end at zero instead of being set again. The bench provokes this for every class code. It loads the flag with a call-with-exchange and then retires each class. It expects a single fault pulse with the flag cleared, except for the clear class, which must pass with no fault. The bench computes every expected value from the operand rules rather than from the design.

// File: rtl/btf_pkg.sv
package btf_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_OTHER        = 4'd0,
    CL_CLEAR        = 4'd1,
    CL_CALL_XCHG    = 4'd2,
    CL_CALL_XCHG_NS = 4'd3,
    CL_JMP_XCHG     = 4'd4,
    CL_JMP_XCHG_NS  = 4'd5,
    CL_LD_ROFS      = 4'd6,
    CL_LD_LIT       = 4'd7,
    CL_LD_IOFS      = 4'd8,
    CL_LD_MULT      = 4'd9
  } cls_e;
endpackage

// File: rtl/btf_set_rules.sv
module btf_set_rules
  import btf_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int SP_ID = 13,
  parameter int LR_ID = 14,
  parameter int PC_ID = 15
) (
  input  cls_e             cls,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] base,
  input  logic             wb,
  output logic             sets,
  output logic             is_clear
);
  localparam logic [REG_W-1:0] SP_R = REG_W'(SP_ID);
  localparam logic [REG_W-1:0] LR_R = REG_W'(LR_ID);
  localparam logic [REG_W-1:0] PC_R = REG_W'(PC_ID);

  logic pc_dst, sp_base, lr_tgt;
  assign pc_dst  = (dst == PC_R);
  assign sp_base = (base == SP_R);
  assign lr_tgt  = (base == LR_R);

  always_comb begin
    unique case (cls)
      CL_CALL_XCHG, CL_CALL_XCHG_NS: sets = 1'b1;
      CL_JMP_XCHG, CL_JMP_XCHG_NS:   sets = !lr_tgt;
      CL_LD_ROFS, CL_LD_LIT:         sets = pc_dst;
      CL_LD_IOFS, CL_LD_MULT:        sets = pc_dst && (!sp_base || !wb);
      default:                       sets = 1'b0;
    endcase
  end

  assign is_clear = (cls == CL_CLEAR);

  always_comb begin
    // R6
    other_never_sets_chk: assert (!(sets && (cls == CL_OTHER || cls == CL_CLEAR)));
    // R3
    lr_target_no_set_chk: assert (!((cls == CL_JMP_XCHG || cls == CL_JMP_XCHG_NS) && lr_tgt && sets));
  end
endmodule

// File: rtl/btf_state.sv
module btf_state (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic retire,
  input  logic sets,
  input  logic is_clear,
  output logic flag_q,
  output logic fault_q
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      flag_q  <= 1'b0;
      fault_q <= 1'b0;
    end else if (retire) begin
      if (flag_q) begin
        fault_q <= !is_clear;
        flag_q  <= 1'b0;
      end else begin
        fault_q <= 1'b0;
        flag_q  <= sets;
      end
    end else begin
      fault_q <= 1'b0;
    end
  end

  // R8
  fault_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> !flag_q);
  // R8
  fault_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> !fault_q);
  // R9
  idle_holds_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !retire) |=> (flag_q == $past(flag_q)) && !fault_q);
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !flag_q && !fault_q);
  // R7
  clear_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (en && retire && flag_q && is_clear) |=> !fault_q && !flag_q);
endmodule

// File: rtl/btf_tracker.sv
module btf_tracker
  import btf_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int SP_ID = 13,
  parameter int LR_ID = 14,
  parameter int PC_ID = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             retire,
  input  logic [CLS_W-1:0] ins_class,
  input  logic [REG_W-1:0] dst_reg,
  input  logic [REG_W-1:0] base_reg,
  input  logic             base_wb,
  output logic             flag,
  output logic             fault
);
  logic sets, is_clear;

  btf_set_rules #(
    .REG_W(REG_W), .SP_ID(SP_ID), .LR_ID(LR_ID), .PC_ID(PC_ID)
  ) u_rules (
    .cls(cls_e'(ins_class)),
    .dst(dst_reg),
    .base(base_reg),
    .wb(base_wb),
    .sets(sets),
    .is_clear(is_clear)
  );

  btf_state u_state (
    .clk(clk),
    .rst(rst),
    .en(en),
    .retire(retire),
    .sets(sets),
    .is_clear(is_clear),
    .flag_q(flag),
    .fault_q(fault)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> !flag && !fault);
  // R8
  fault_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past(flag) && $past(retire) && $past(en));
endmodule

// File: tb/sim_btf_tracker.sv
module sim_btf_tracker;
  logic clk = 1'b0;
  logic rst, en, retire, base_wb;
  logic [3:0] ins_class, dst_reg, base_reg;
  logic flag, fault;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  btf_tracker u0 (
    .clk(clk), .rst(rst), .en(en), .retire(retire), .ins_class(ins_class),
    .dst_reg(dst_reg), .base_reg(base_reg), .base_wb(base_wb),
    .flag(flag), .fault(fault)
  );

  function automatic bit exp_set(int c, int d, int b, int w);
    case (c)
      2, 3:    return 1'b1;
      4, 5:    return b != 14;
      6, 7:    return d == 15;
      8, 9:    return (d == 15) && ((b != 13) || (w == 0));
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, bit ef, bit eu);
    n_chk++;
    if (flag !== ef || fault !== eu) begin
      n_fail++;
      $display("FAIL %s: flag=%b fault=%b expected flag=%b fault=%b (cls=%0d dst=%0d base=%0d wb=%b)",
               req, flag, fault, ef, eu, ins_class, dst_reg, base_reg, base_wb);
    end
  endtask

  task automatic step(bit e, bit r, int c, int d, int b, int w);
    @(negedge clk);
    en = e; retire = r; ins_class = 4'(c); dst_reg = 4'(d);
    base_reg = 4'(b); base_wb = 1'(w);
    @(posedge clk);
    #2;
  endtask

  function automatic string rule_tag(int c);
    case (c)
      2, 3:    return "R2";
      4, 5:    return "R3";
      6, 7:    return "R4";
      8, 9:    return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    rst = 1'b1; en = 1'b1; retire = 1'b0; ins_class = '0;
    dst_reg = '0; base_reg = '0; base_wb = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    check("R1", 1'b0, 1'b0);

    // Setting rules: sweep every class, register pair and write-back value.
    for (int c = 0; c < 16; c++)
      for (int d = 0; d < 16; d++)
        for (int b = 0; b < 16; b++)
          for (int w = 0; w < 2; w++) begin
            bit s;
            s = exp_set(c, d, b, w);
            step(1'b1, 1'b1, c, d, b, w);
            check(rule_tag(c), s, 1'b0);
            if (s) begin
              step(1'b1, 1'b1, 1, 0, 0, 0);
              check("R7", 1'b0, 1'b0);
            end
          end

    // Flag set, then every class retires next: fault unless clear (R8 vs R7).
    for (int c = 0; c < 16; c++) begin
      step(1'b1, 1'b1, 2, 0, 0, 0);
      check("R2", 1'b1, 1'b0);
      step(1'b1, 1'b0, 0, 0, 0, 0);
      check("R9", 1'b1, 1'b0);
      step(1'b1, 1'b1, c, 15, 0, 0);
      if (c == 1) check("R7", 1'b0, 1'b0);
      else check("R8", 1'b0, 1'b1);
      step(1'b1, 1'b0, 0, 0, 0, 0);
      check("R8", 1'b0, 1'b0);
    end

    // Enable low: setting retire ignored, held flag dropped.
    step(1'b0, 1'b1, 2, 0, 0, 0);
    check("R10", 1'b0, 1'b0);
    step(1'b1, 1'b1, 3, 0, 0, 0);
    check("R2", 1'b1, 1'b0);
    step(1'b0, 1'b1, 0, 0, 0, 0);
    check("R10", 1'b0, 1'b0);
    step(1'b1, 1'b1, 0, 0, 0, 0);
    check("R10", 1'b0, 1'b0);

    // Reset while flag set.
    step(1'b1, 1'b1, 7, 15, 0, 0);
    check("R4", 1'b1, 1'b0);
    @(negedge clk); rst = 1'b1; retire = 1'b0;
    @(posedge clk); #2;
    check("R1", 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule